// File: doc/BRIEF.md
# Chunked Block Reader for a Memory Card in SPI Mode

This block fetches a contiguous run of bytes from a memory card that speaks the SPI-mode command protocol. It hands the bytes to a consumer in chunks of a fixed length. The length is chosen per request. A request gives a start byte address, a total byte count, the chunk length and a cap on how long to poll for the data start token.

The reader selects the card and sends a single-block read command for the 512-byte block that holds the start address. It waits for the card's response and then for the start token. It discards the bytes that come before the requested position. It then streams whole chunks on a byte-wide valid/ready port. Each chunk is tagged with the absolute address of its first byte.

The tail of each block and the two CRC bytes are thrown away, and the reader moves on to the next block. It stops when the remaining count is below one chunk, or when the consumer raises the stop input on the last byte of a chunk. It finishes by deselecting the card, clocking one trailing byte and pulsing `done` with a status code.

Byte transfers go through a separate SPI byte engine, which is not part of this block. The reader raises `spi_req` with `spi_tx`, and the engine answers with a one-cycle `spi_ack` and the received byte on `spi_rx`.

Top module: `sd_chunk_reader`

## Requirements
- R1: A request whose chunk length is 0, is larger than 512, or is larger than the total length is refused. `done` pulses with status 1, and the card is never selected and no byte is transferred. Status codes are: 0 success, 1 refused, 2 bad or missing command response, 3 start-token timeout.
- R2: Each block read starts with `spi_cs_n` low and a 6-byte frame: 0x51, then the 32-bit block base most significant byte first, then 0xFF. The block base is the address with its low 9 bits cleared. During every byte transfer, `spi_req` and `spi_tx` stay steady until `spi_ack`.
- R3: After the frame, up to NCR_MAX bytes are clocked looking for a byte with bit 7 clear. If that byte is nonzero, or if no such byte arrives, the request ends with status 2.
- R4: The reader then clocks bytes until it sees 0xFE. If `tok_polls` bytes in a row are not 0xFE, the request ends with status 3.
- R5: In the first block, the bytes before the in-block position (the low 9 address bits) are never delivered. The first chunk is tagged with the requested address when it fits in that block.
- R6: A chunk starts only while both the bytes left in the block and the remaining total are at least one chunk length. Its bytes come out in card order. `chunk_first` marks byte 0 and `chunk_last` marks the final byte. `chunk_addr` holds the absolute address of byte 0. Any bytes not used in the block are discarded.
- R7: After data byte 511, two CRC bytes are clocked and discarded. If at least one chunk length remains, the next read targets the previous block base plus 512.
- R8: `chunk_stop` is sampled with the handshake of a chunk's last byte. When it is high, no further chunk is delivered, the current block and its CRC are drained, and the request ends with status 0.
- R9: Every request that selected the card ends the same way: `spi_cs_n` goes high, exactly one byte is clocked while deselected, and then `done` pulses for one cycle.
- R10: While `chunk_valid` is high and `chunk_ready` is low, the data, address and flags on the chunk port do not change.
- R11: After reset, `spi_cs_n` is high, and `busy`, `done`, `spi_req` and `chunk_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| start_addr | input | ADDR_W | First byte address |
| start_len | input | LEN_W | Total bytes wanted |
| start_chunk | input | LEN_W | Chunk length in bytes |
| tok_polls | input | POLL_W | Limit on non-token bytes before timeout |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 2 | Result code of the last request |
| spi_cs_n | output | 1 | Card select, active low |
| spi_req | output | 1 | Byte transfer request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Transfer complete, `spi_rx` valid |
| spi_rx | input | 8 | Byte received |
| chunk_valid | output | 1 | Chunk byte available |
| chunk_ready | input | 1 | Consumer accepts byte |
| chunk_data | output | 8 | Chunk byte |
| chunk_first | output | 1 | First byte of a chunk |
| chunk_last | output | 1 | Last byte of a chunk |
| chunk_addr | output | ADDR_W | Absolute address of the chunk's first byte |
| chunk_stop | input | 1 | Consumer asks to stop after this chunk |

## Verification
The bench builds the reader with its default parameters: 32-bit addresses, 16-bit lengths, a 16-bit poll limit and NCR_MAX of 8.

An 8-byte response window lets a card model that delays its response by 10 fill bytes overrun it, while a delay of 3 still succeeds. The bench also sets `tok_polls` to 3 for some requests, so a token timeout and its near miss each cost only a few bytes. 16-bit lengths allow a 1024-byte request with 512-byte chunks, which crosses into a second block. Chunk lengths of 1 and 20 cover a chunk that is a single byte and a start that cannot fit before the block end.

// File: rtl/sd_chunk_reader.sv
module sd_chunk_reader #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int POLL_W  = 16,
  parameter int NCR_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [LEN_W-1:0]  start_chunk,
  input  logic [POLL_W-1:0] tok_polls,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              spi_cs_n,
  output logic              spi_req,
  output logic [7:0]        spi_tx,
  input  logic              spi_ack,
  input  logic [7:0]        spi_rx,
  output logic              chunk_valid,
  input  logic              chunk_ready,
  output logic [7:0]        chunk_data,
  output logic              chunk_first,
  output logic              chunk_last,
  output logic [ADDR_W-1:0] chunk_addr,
  input  logic              chunk_stop
);
  localparam int BLK   = 512;
  localparam int OFS_W = 9;
  localparam int POS_W = OFS_W + 1;
  localparam logic [1:0] ST_OK  = 2'd0;
  localparam logic [1:0] ST_BAD = 2'd1;
  localparam logic [1:0] ST_RSP = 2'd2;
  localparam logic [1:0] ST_TMO = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RSP, S_TOK, S_DATA, S_HOLD, S_CRC, S_TAIL} st_t;
  st_t st;

  logic [ADDR_W-1:0] base;
  logic [POS_W-1:0]  pos;
  logic [OFS_W-1:0]  skip;
  logic [LEN_W-1:0]  rem, iv, left;
  logic [POLL_W-1:0] plim, cnt;
  logic [2:0]        idx;
  logic              in_chunk, stop_req;
  logic [1:0]        err;

  wire [POS_W-1:0]  room      = POS_W'(BLK) - pos;
  wire              fits      = (LEN_W'(room) >= iv) && (rem >= iv) && !stop_req;
  wire              past_skip = pos >= POS_W'(skip);
  wire              take      = past_skip && (in_chunk || fits);
  wire              bad       = (start_chunk == '0) || (start_len < start_chunk) ||
                                (start_chunk > LEN_W'(BLK));
  wire              xfer      = spi_req && spi_ack;
  wire [POLL_W:0]   cnt_nx    = {1'b0, cnt} + 1'b1;
  wire [31:0]       arg       = 32'(base);

  assign busy     = (st != S_IDLE);
  assign spi_req  = (st == S_CMD) || (st == S_RSP) || (st == S_TOK) ||
                    (st == S_DATA) || (st == S_CRC) || (st == S_TAIL);
  assign spi_cs_n = (st == S_IDLE) || (st == S_TAIL);

  always_comb begin
    spi_tx = 8'hFF;
    if (st == S_CMD) begin
      case (idx)
        3'd0:    spi_tx = 8'h51;
        3'd1:    spi_tx = arg[31:24];
        3'd2:    spi_tx = arg[23:16];
        3'd3:    spi_tx = arg[15:8];
        3'd4:    spi_tx = arg[7:0];
        default: spi_tx = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      done        <= 1'b0;
      status      <= ST_OK;
      base        <= '0;
      pos         <= '0;
      skip        <= '0;
      rem         <= '0;
      iv          <= '0;
      left        <= '0;
      plim        <= '0;
      cnt         <= '0;
      idx         <= '0;
      in_chunk    <= 1'b0;
      stop_req    <= 1'b0;
      err         <= ST_OK;
      chunk_valid <= 1'b0;
      chunk_data  <= '0;
      chunk_first <= 1'b0;
      chunk_last  <= 1'b0;
      chunk_addr  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad) begin
            done   <= 1'b1;
            status <= ST_BAD;
          end else begin
            base     <= start_addr & ~ADDR_W'(BLK - 1);
            skip     <= start_addr[OFS_W-1:0];
            pos      <= '0;
            rem      <= start_len;
            iv       <= start_chunk;
            plim     <= tok_polls;
            stop_req <= 1'b0;
            in_chunk <= 1'b0;
            err      <= ST_OK;
            idx      <= '0;
            st       <= S_CMD;
          end
        end
        S_CMD: if (xfer) begin
          idx <= idx + 3'd1;
          if (idx == 3'd5) begin
            cnt <= '0;
            st  <= S_RSP;
          end
        end
        S_RSP: if (xfer) begin
          if (!spi_rx[7]) begin
            if (spi_rx == 8'h00) begin
              cnt <= '0;
              st  <= S_TOK;
            end else begin
              err <= ST_RSP;
              st  <= S_TAIL;
            end
          end else if (cnt == POLL_W'(NCR_MAX - 1)) begin
            err <= ST_RSP;
            st  <= S_TAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TOK: if (xfer) begin
          if (spi_rx == 8'hFE) begin
            pos <= '0;
            st  <= S_DATA;
          end else if (cnt_nx >= {1'b0, plim}) begin
            err <= ST_TMO;
            st  <= S_TAIL;
          end else begin
            cnt <= cnt_nx[POLL_W-1:0];
          end
        end
        S_DATA: if (xfer) begin
          pos <= pos + 1'b1;
          if (take) begin
            chunk_data  <= spi_rx;
            chunk_valid <= 1'b1;
            chunk_first <= !in_chunk;
            if (!in_chunk) begin
              chunk_addr <= base + ADDR_W'(pos);
              left       <= iv - 1'b1;
              chunk_last <= (iv == LEN_W'(1));
              in_chunk   <= 1'b1;
            end else begin
              left       <= left - 1'b1;
              chunk_last <= (left == LEN_W'(1));
            end
            st <= S_HOLD;
          end else if (pos == POS_W'(BLK - 1)) begin
            idx <= '0;
            st  <= S_CRC;
          end
        end
        S_HOLD: if (chunk_ready) begin
          chunk_valid <= 1'b0;
          if (chunk_last) begin
            in_chunk <= 1'b0;
            rem      <= rem - iv;
            if (chunk_stop) stop_req <= 1'b1;
          end
          idx <= '0;
          st  <= (pos == POS_W'(BLK)) ? S_CRC : S_DATA;
        end
        S_CRC: if (xfer) begin
          idx <= idx + 3'd1;
          if (idx == 3'd1) begin
            if (stop_req || (rem < iv)) begin
              st <= S_TAIL;
            end else begin
              base <= base + ADDR_W'(BLK);
              pos  <= '0;
              skip <= '0;
              idx  <= '0;
              st   <= S_CMD;
            end
          end
        end
        S_TAIL: if (xfer) begin
          done   <= 1'b1;
          status <= err;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_data) &&
      $stable(chunk_addr) && $stable(chunk_first) && $stable(chunk_last));

  // R2
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && !spi_ack |=> spi_req && $stable(spi_tx));

  // R6
  full_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> rem >= iv);

  // R8
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !(chunk_valid && chunk_first));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n && !spi_req && !chunk_valid);

  // R7
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(BLK));
endmodule

// File: tb/sd_chunk_reader_tb.sv
module sd_chunk_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] start_len = '0, start_chunk = '0, tok_polls = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic        spi_cs_n, spi_req, spi_ack;
  logic [7:0]  spi_tx, spi_rx;
  logic        chunk_valid, chunk_ready, chunk_first, chunk_last, chunk_stop;
  logic [7:0]  chunk_data;
  logic [31:0] chunk_addr;

  always #5 clk = ~clk;

  sd_chunk_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .start_chunk(start_chunk), .tok_polls(tok_polls),
    .busy(busy), .done(done), .status(status),
    .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready), .chunk_data(chunk_data),
    .chunk_first(chunk_first), .chunk_last(chunk_last), .chunk_addr(chunk_addr),
    .chunk_stop(chunk_stop)
  );

  typedef struct packed {
    logic [31:0] off;  logic [15:0] len;  logic [15:0] iv;   logic [7:0] stopn;
    logic [7:0]  r1d;  logic [7:0]  r1v;  logic [7:0]  tokd; logic [15:0] plim;
    logic [1:0]  thr;  logic [1:0]  est;  logic [7:0]  echk; logic [7:0] ecmd;
    logic [31:0] etag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{32'd0,    16'd64,   16'd16,  8'd0, 8'd1,  8'h00, 8'd2, 16'd100, 2'd0, 2'd0, 8'd4, 8'd1, 32'd0},
    '{32'd560,  16'd96,   16'd32,  8'd0, 8'd0,  8'h00, 8'd0, 16'd100, 2'd1, 2'd0, 8'd3, 8'd1, 32'd560},
    '{32'd480,  16'd64,   16'd32,  8'd0, 8'd1,  8'h00, 8'd1, 16'd100, 2'd2, 2'd0, 8'd2, 8'd2, 32'd480},
    '{32'd500,  16'd40,   16'd20,  8'd0, 8'd0,  8'h00, 8'd3, 16'd100, 2'd0, 2'd0, 8'd2, 8'd2, 32'd512},
    '{32'd0,    16'd128,  16'd16,  8'd2, 8'd0,  8'h00, 8'd0, 16'd100, 2'd1, 2'd0, 8'd2, 8'd1, 32'd0},
    '{32'd0,    16'd40,   16'd16,  8'd0, 8'd0,  8'h00, 8'd0, 16'd100, 2'd0, 2'd0, 8'd2, 8'd1, 32'd0},
    '{32'd0,    16'd1024, 16'd512, 8'd0, 8'd0,  8'h00, 8'd0, 16'd100, 2'd0, 2'd0, 8'd2, 8'd2, 32'd0},
    '{32'd0,    16'd64,   16'd0,   8'd0, 8'd0,  8'h00, 8'd0, 16'd100, 2'd0, 2'd1, 8'd0, 8'd0, 32'd0},
    '{32'd0,    16'd8,    16'd16,  8'd0, 8'd0,  8'h00, 8'd0, 16'd100, 2'd0, 2'd1, 8'd0, 8'd0, 32'd0},
    '{32'd600,  16'd600,  16'd600, 8'd0, 8'd0,  8'h00, 8'd0, 16'd100, 2'd0, 2'd1, 8'd0, 8'd0, 32'd0},
    '{32'd0,    16'd16,   16'd16,  8'd0, 8'd0,  8'h04, 8'd0, 16'd100, 2'd0, 2'd2, 8'd0, 8'd1, 32'd0},
    '{32'd0,    16'd16,   16'd16,  8'd0, 8'd0,  8'h00, 8'd2, 16'd3,   2'd0, 2'd0, 8'd1, 8'd1, 32'd0},
    '{32'd0,    16'd16,   16'd16,  8'd0, 8'd0,  8'h00, 8'd3, 16'd3,   2'd0, 2'd3, 8'd0, 8'd1, 32'd0},
    '{32'd0,    16'd16,   16'd16,  8'd0, 8'd3,  8'h00, 8'd0, 16'd100, 2'd0, 2'd0, 8'd1, 8'd1, 32'd0},
    '{32'd0,    16'd16,   16'd16,  8'd0, 8'd10, 8'h00, 8'd0, 16'd100, 2'd0, 2'd2, 8'd0, 8'd1, 32'd0},
    '{32'd1030, 16'd3,    16'd1,   8'd0, 8'd0,  8'h00, 8'd0, 16'd100, 2'd3, 2'd0, 8'd3, 8'd1, 32'd1030},
    '{32'd480,  16'd96,   16'd32,  8'd1, 8'd0,  8'h00, 8'd0, 16'd100, 2'd0, 2'd0, 8'd1, 8'd1, 32'd480}
  };

  function automatic logic [7:0] cb(input logic [31:0] a);
    return a[7:0] ^ {a[10:8], a[12:11], a[15:13]};
  endfunction

  // per-test configuration, written only by the main initial block
  logic [7:0]  cfg_r1d = '0, cfg_r1v = '0, cfg_tokd = '0, cfg_stop = '0;
  logic [1:0]  cfg_thr = '0;
  logic [15:0] cfg_iv = 16'd1;
  logic [31:0] cfg_tag = '0;
  int          nch_base = 0;

  // card model
  int          ncmds = 0, ntrail = 0, ntotal = 0;
  logic [47:0] cmd_log [64];
  logic [2:0]  cph = '0, ccnt = '0;
  logic [39:0] cmdb = '0;
  logic [7:0]  wcnt = '0;
  logic [9:0]  didx = '0;
  logic [31:0] caddr = '0;

  initial begin
    spi_ack = 1'b0;
    spi_rx = 8'hFF;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      spi_ack <= 1'b0;
      cph <= '0;
      ccnt <= '0;
    end else if (spi_req && !spi_ack) begin
      spi_ack <= 1'b1;
      ntotal <= ntotal + 1;
      spi_rx <= 8'hFF;
      if (spi_cs_n) begin
        ntrail <= ntrail + 1;
        cph <= '0;
        ccnt <= '0;
      end else begin
        case (cph)
          3'd0: begin
            cmdb <= {cmdb[31:0], spi_tx};
            if (ccnt == 3'd5) begin
              cmd_log[ncmds[5:0]] <= {cmdb, spi_tx};
              caddr <= cmdb[31:0];
              ncmds <= ncmds + 1;
              ccnt <= '0;
              cph <= 3'd1;
              wcnt <= cfg_r1d;
            end else ccnt <= ccnt + 3'd1;
          end
          3'd1: begin
            if (wcnt != 0) wcnt <= wcnt - 8'd1;
            else begin
              spi_rx <= cfg_r1v;
              wcnt <= cfg_tokd;
              cph <= (cfg_r1v == 8'h00) ? 3'd2 : 3'd0;
            end
          end
          3'd2: begin
            if (wcnt != 0) wcnt <= wcnt - 8'd1;
            else begin
              spi_rx <= 8'hFE;
              didx <= '0;
              cph <= 3'd3;
            end
          end
          3'd3: begin
            spi_rx <= cb(caddr + 32'(didx));
            didx <= didx + 10'd1;
            if (didx == 10'd511) begin
              cph <= 3'd4;
              ccnt <= '0;
            end
          end
          3'd4: begin
            spi_rx <= ccnt[0] ? 8'h55 : 8'hAA;
            ccnt <= ccnt + 3'd1;
            if (ccnt == 3'd1) begin
              cph <= 3'd0;
              ccnt <= '0;
            end
          end
          default: cph <= '0;
        endcase
      end
    end else begin
      spi_ack <= 1'b0;
    end
  end

  // consumer and stream monitor
  int          nch_all = 0, merr = 0, nbytes = 0, tcnt = 0;
  int          bidx = 0;
  logic [31:0] ptag = '0;

  initial begin
    chunk_ready = 1'b1;
    chunk_stop = 1'b0;
  end

  always @(negedge clk) begin
    tcnt = tcnt + 1;
    chunk_ready = (cfg_thr == 2'd0) || ((tcnt % (int'(cfg_thr) + 1)) == 0);
    chunk_stop = 1'b0;
    if (rst_n && chunk_valid && chunk_ready) begin
      nbytes = nbytes + 1;
      if (chunk_first) begin
        bidx = 0;
        if (nch_all != nch_base) begin
          if (chunk_addr != ptag + 32'(cfg_iv)) merr = merr + 1;
        end else if (chunk_addr != cfg_tag) merr = merr + 1;
        ptag = chunk_addr;
      end
      if (chunk_data != cb(ptag + 32'(bidx))) merr = merr + 1;
      if (chunk_last != (bidx == int'(cfg_iv) - 1)) merr = merr + 1;
      if (chunk_last) begin
        nch_all = nch_all + 1;
        if (cfg_stop != 0 && (nch_all - nch_base) == int'(cfg_stop)) chunk_stop = 1'b1;
      end
      bidx = bidx + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic ck(input bit ok, input string req, input string what,
                    input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int c0, t0, tr0, m0, n;
    string rq;
    cfg_r1d = v.r1d; cfg_r1v = v.r1v; cfg_tokd = v.tokd; cfg_stop = v.stopn;
    cfg_thr = v.thr; cfg_iv = v.iv; cfg_tag = v.etag;
    nch_base = nch_all;
    c0 = ncmds; t0 = ntotal; tr0 = ntrail; m0 = merr;
    @(negedge clk);
    start = 1'b1; start_addr = v.off; start_len = v.len;
    start_chunk = v.iv; tok_polls = v.plim;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) begin
      ck(1'b0, "R9", "watchdog expired", n, 0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      return;
    end
    case (v.est)
      2'd1: rq = "R1";
      2'd2: rq = "R3";
      2'd3: rq = "R4";
      default: rq = (v.stopn != 0) ? "R8" : "R6";
    endcase
    ck(status == v.est, rq, "status", status, v.est);
    ck((nch_all - nch_base) == int'(v.echk), rq, "chunk count", nch_all - nch_base, v.echk);
    ck(merr == m0, (v.thr != 0) ? "R10" : "R6", "chunk byte/tag/flag errors", merr - m0, 0);
    ck((ncmds - c0) == int'(v.ecmd), "R7", "block reads", ncmds - c0, v.ecmd);
    if (v.est == 2'd1) begin
      ck((ntotal - t0) == 0, "R1", "transfers on refused request", ntotal - t0, 0);
    end else begin
      ck((ntrail - tr0) == 1, "R9", "deselected trailing bytes", ntrail - tr0, 1);
      ck(cmd_log[c0[5:0]][47:40] == 8'h51, "R2", "command byte", cmd_log[c0[5:0]][47:40], 8'h51);
      ck(cmd_log[c0[5:0]][7:0] == 8'hFF, "R2", "frame trailer byte", cmd_log[c0[5:0]][7:0], 8'hFF);
      ck(cmd_log[c0[5:0]][39:8] == (v.off & ~32'd511), "R2", "block base",
         cmd_log[c0[5:0]][39:8], v.off & ~32'd511);
      if (v.ecmd > 1)
        ck(cmd_log[(c0 + int'(v.ecmd) - 1) % 64][39:8] == (v.off & ~32'd511) + 512 * (int'(v.ecmd) - 1),
           "R7", "last block base", cmd_log[(c0 + int'(v.ecmd) - 1) % 64][39:8],
           (v.off & ~32'd511) + 512 * (int'(v.ecmd) - 1));
      if (v.echk > 0 && v.off[8:0] != 0)
        ck(v.etag >= v.off, "R5", "first tag not before offset", v.etag, v.off);
    end
    ck(spi_cs_n == 1'b1 && !busy, "R9", "idle after done", {spi_cs_n, busy}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    ck(spi_cs_n == 1'b1, "R11", "cs_n in reset", spi_cs_n, 1);
    ck({busy, done, spi_req, chunk_valid} == 4'b0, "R11", "outputs in reset",
       {busy, done, spi_req, chunk_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ck(spi_cs_n == 1'b1 && !busy, "R11", "idle after reset", {spi_cs_n, busy}, 2'b10);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // reset in the middle of a streaming request
    cfg_r1d = 0; cfg_r1v = 0; cfg_tokd = 0; cfg_stop = 0; cfg_thr = 2'd2;
    cfg_iv = 16'd16; cfg_tag = 0; nch_base = nch_all;
    @(negedge clk);
    start = 1'b1; start_addr = 32'd0; start_len = 16'd256; start_chunk = 16'd16; tok_polls = 16'd100;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    ck(busy == 1'b1, "R11", "busy before mid-run reset", busy, 1);
    rst_n = 1'b0;
    @(negedge clk);
    ck(spi_cs_n == 1'b1, "R11", "cs_n after mid-run reset", spi_cs_n, 1);
    ck({busy, done, spi_req, chunk_valid} == 4'b0, "R11", "outputs after mid-run reset",
       {busy, done, spi_req, chunk_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_vec(VEC[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule